// File: doc/BRIEF.md
# E1 Receive Alarm Latched Status

This block watches one E1 receive port and keeps an 8-bit sticky status register. It tracks three conditions. The first is loss of the receive bit clock. The second is the distant multiframe alarm carried in the time-slot 16 byte. The third is a V5.2 link indication that arrives as a level from other logic. For each condition the block latches two events: a "detected" bit on the condition's rising edge and a "cleared" bit on its falling edge.

Software clears a latched bit by writing a one to it. Each bit has an enable, and the enabled bits are ORed into a single interrupt output. The receive bit clock is oversampled in the system clock domain. The framer gives a one-cycle strobe for each time-slot 16 byte, together with a flag that marks frame 0 of the multiframe. This block does not do frame alignment or recognise the V5.2 pattern.

Top module: `e1_alarm_status`

## Requirements
- R1: Status bit map: 0 = multiframe alarm detected, 1 = V5.2 link detected, 3 = clock loss detected, 4 = multiframe alarm cleared, 5 = V5.2 link cleared, 7 = clock loss cleared. Bits 2 and 6 always read 0. After reset the status is 0x00, the enable register is 0x00 and `irq` is low.
- R2: A latched bit stays at 1 until software clears it, even after its condition has changed back.
- R3: The clock-loss condition becomes true once `rx_clk_in` has made no transition for CLKS_PER_BIT*CHANNEL_BITS system clocks, after a two-flop synchroniser. Any transition ends it. Pauses shorter than the limit produce no event.
- R4: Bit 3 sets when clock loss begins. Bit 7 sets when the receive clock toggles again.
- R5: The multiframe alarm condition sets after CONFIRM consecutive frame-0 time-slot 16 strobes (`ts16_valid` and `ts16_frame0` both high) with `ts16_byte[2]` at 1. Bit 7 of the byte is the first bit received, so bit 2 is the sixth. Strobes with `ts16_frame0` low are ignored and do not break a run. The rising edge of the condition sets status bit 0.
- R6: The multiframe alarm condition clears after CONFIRM consecutive frame-0 strobes with `ts16_byte[2]` at 0. A strobe of the opposite value restarts the run. The falling edge of the condition sets status bit 4.
- R7: A rising edge of `v52_link` sets bit 1, and a falling edge sets bit 5.
- R8: A cycle with `wr_en` high clears every status bit where `wr_data` is 1. Bits where `wr_data` is 0 are left unchanged.
- R9: When an event and a clear hit the same bit in the same cycle, the bit ends up at 1.
- R10: `irq` is high exactly when some status bit and the matching bit of the enable register, written by `ien_we`/`ien_data`, are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_clk_in | input | 1 | Receive bit clock, oversampled |
| ts16_valid | input | 1 | One-cycle strobe carrying a time-slot 16 byte |
| ts16_frame0 | input | 1 | The strobed byte belongs to frame 0 |
| ts16_byte | input | 8 | Time-slot 16 byte, bit 7 received first |
| v52_link | input | 1 | V5.2 link indication level |
| wr_en | input | 1 | Write-one-to-clear strobe for the status |
| wr_data | input | 8 | Bits to clear |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_data | input | 8 | New enable value |
| status | output | 8 | Latched status register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CLKS_PER_BIT=4, CHANNEL_BITS=8 and CONFIRM=2. With these values the clock-loss window is only 32 system clocks. That makes both sides of the window reachable: a 20-cycle pause must produce nothing, and a 50-cycle pause must latch detect and then clear. With CONFIRM=2 the bench can drive single-multiframe glitches, interleaved frames other than frame 0, and interrupted runs in a few strobes. It also checks the same-cycle race between an event and a clear, and interrupt masking per bit.

// File: rtl/e1a_pkg.sv
package e1a_pkg;
  localparam int unsigned NCOND = 3;
  localparam int unsigned SW    = 8;
  // condition index
  localparam int unsigned C_MF  = 0;
  localparam int unsigned C_V52 = 1;
  localparam int unsigned C_LOS = 2;
  // bits that hold state; 2 and 6 are tied low
  localparam logic [SW-1:0] IMPL_MASK = 8'hBB;

  // Places condition edges at their status positions (decoded by software).
  function automatic logic [SW-1:0] place_events(input logic [NCOND-1:0] rise,
                                                 input logic [NCOND-1:0] fall);
    logic [SW-1:0] v;
    v    = '0;
    v[0] = rise[C_MF];
    v[1] = rise[C_V52];
    v[3] = rise[C_LOS];
    v[4] = fall[C_MF];
    v[5] = fall[C_V52];
    v[7] = fall[C_LOS];
    return v;
  endfunction
endpackage

// File: rtl/e1a_clk_loss.sv
module e1a_clk_loss #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned CHANNEL_BITS = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk_in,
  output logic rx_edge,
  output logic loss
);
  localparam int unsigned LIMIT = CLKS_PER_BIT * CHANNEL_BITS;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [SYNC_STAGES:0] sh;
  logic [CW-1:0]        quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], rx_clk_in};
  end

  assign rx_edge = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    quiet <= '0;
    else if (rx_edge)              quiet <= '0;
    else if (quiet != CW'(LIMIT))  quiet <= quiet + CW'(1);
  end

  assign loss = (quiet == CW'(LIMIT));
endmodule

// File: rtl/e1a_mf_alarm.sv
module e1a_mf_alarm #(
  parameter int unsigned CONFIRM   = 2,
  parameter int unsigned ALARM_POS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ts16_valid,
  input  logic       ts16_frame0,
  input  logic [7:0] ts16_byte,
  output logic       alarm
);
  localparam int unsigned RW = $clog2(CONFIRM + 1);

  logic [RW-1:0] run;
  logic          sample;

  assign sample = ts16_byte[ALARM_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= 1'b0;
      run   <= '0;
    end else if (ts16_valid && ts16_frame0) begin
      if (sample != alarm) begin
        if (run == RW'(CONFIRM - 1)) begin
          alarm <= sample;
          run   <= '0;
        end else begin
          run <= run + RW'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/e1a_status_reg.sv
module e1a_status_reg
  import e1a_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] ev,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic          ien_we,
  input  logic [SW-1:0] ien_data,
  output logic [SW-1:0] status,
  output logic [SW-1:0] ien,
  output logic          irq
);
  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   status[i] <= 1'b0;
        else if (ev[i])               status[i] <= 1'b1;
        else if (wr_en && wr_data[i]) status[i] <= 1'b0;
      end
    end else begin : g_tied
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien <= '0;
    else if (ien_we) ien <= ien_data;
  end

  assign irq = |(status & ien);
endmodule

// File: rtl/e1_alarm_status.sv
module e1_alarm_status
  import e1a_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned CHANNEL_BITS = 8,
  parameter int unsigned CONFIRM      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_clk_in,
  input  logic       ts16_valid,
  input  logic       ts16_frame0,
  input  logic [7:0] ts16_byte,
  input  logic       v52_link,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ien_we,
  input  logic [7:0] ien_data,
  output logic [7:0] status,
  output logic       irq
);
  logic             rxc_edge;
  logic             loss_cond;
  logic             mf_cond;
  logic [NCOND-1:0] cond, cond_q;
  logic [SW-1:0]    ev_vec;
  logic [SW-1:0]    ien_q;

  e1a_clk_loss #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CHANNEL_BITS(CHANNEL_BITS),
    .SYNC_STAGES (2)
  ) u_loss (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_clk_in(rx_clk_in),
    .rx_edge  (rxc_edge),
    .loss     (loss_cond)
  );

  e1a_mf_alarm #(
    .CONFIRM  (CONFIRM),
    .ALARM_POS(2)
  ) u_mf (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts16_valid (ts16_valid),
    .ts16_frame0(ts16_frame0),
    .ts16_byte  (ts16_byte),
    .alarm      (mf_cond)
  );

  always_comb begin
    cond        = '0;
    cond[C_MF]  = mf_cond;
    cond[C_V52] = v52_link;
    cond[C_LOS] = loss_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond;
  end

  assign ev_vec = place_events(cond & ~cond_q, ~cond & cond_q);

  e1a_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ien_we  (ien_we),
    .ien_data(ien_data),
    .status  (status),
    .ien     (ien_q),
    .irq     (irq)
  );
endmodule

// File: rtl/e1_alarm_status_chk.sv
module e1_alarm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic [7:0] ien_q,
  input logic       irq,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ev_vec,
  input logic       rxc_edge,
  input logic       loss_cond
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status == 8'h00 && ien_q == 8'h00));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));

  a_r3_edge_ends_loss: assert property (@(posedge clk) disable iff (!rst_n)
    rxc_edge |=> !loss_cond);

  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status & $past(wr_data) & ~$past(ev_vec)) == 8'h00));

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != 8'h00) |=> ((status & $past(ev_vec)) == $past(ev_vec)));

  a_r10_irq_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ien_q) != 8'h00));
endmodule

bind e1_alarm_status e1_alarm_status_chk u_chk (.*);

// File: tb/e1_alarm_status_test.sv
module e1_alarm_status_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_clk_in = 1'b0;
  logic       ts16_valid = 1'b0;
  logic       ts16_frame0 = 1'b0;
  logic [7:0] ts16_byte = 8'h00;
  logic       v52_link = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ien_we = 1'b0;
  logic [7:0] ien_data = 8'h00;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit rx_run = 1'b1;
  int rx_div = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  e1_alarm_status #(.CLKS_PER_BIT(4), .CHANNEL_BITS(8), .CONFIRM(2)) uut (
    .clk(clk), .rst_n(rst_n), .rx_clk_in(rx_clk_in),
    .ts16_valid(ts16_valid), .ts16_frame0(ts16_frame0), .ts16_byte(ts16_byte),
    .v52_link(v52_link), .wr_en(wr_en), .wr_data(wr_data),
    .ien_we(ien_we), .ien_data(ien_data), .status(status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // receive bit clock: period of 4 system clocks while running
  initial forever begin
    @(negedge clk);
    if (rx_run) begin
      rx_div++;
      if (rx_div == 2) begin
        rx_div = 0;
        rx_clk_in = ~rx_clk_in;
      end
    end
  end

  // monitor: pops expected items and compares against the outputs
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (status !== e[7:0] || irq !== e[8]) begin
        errors++;
        $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
                 t, status, irq, e[7:0], e[8]);
      end
    end
  end

  task automatic expect_out(input logic [7:0] st, input logic iv, input string tag);
    exp_q.push_back({iv, st});
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_clear(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic set_ien(input logic [7:0] d);
    ien_we = 1'b1; ien_data = d;
    @(negedge clk);
    ien_we = 1'b0;
  endtask

  task automatic ts16(input logic f0, input logic [7:0] b);
    ts16_valid = 1'b1; ts16_frame0 = f0; ts16_byte = b;
    @(negedge clk);
    ts16_valid = 1'b0; ts16_frame0 = 1'b0; ts16_byte = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out(8'h00, 1'b0, "R1 reset state");

    // R3: running clock and a short pause give no event
    step(20);
    expect_out(8'h00, 1'b0, "R3 running clock");
    rx_run = 1'b0; step(20); rx_run = 1'b1; step(10);
    expect_out(8'h00, 1'b0, "R3 pause under limit");

    // R4: long pause then resume
    rx_run = 1'b0; step(50);
    expect_out(8'h08, 1'b0, "R4 loss detect");
    rx_run = 1'b1; step(10);
    expect_out(8'h88, 1'b0, "R4 loss cleared");

    // R8: write-one-to-clear
    host_clear(8'h08);
    expect_out(8'h80, 1'b0, "R8 clear bit3 only");
    host_clear(8'h00);
    expect_out(8'h80, 1'b0, "R8 zero write no effect");
    host_clear(8'hFF);
    expect_out(8'h00, 1'b0, "R8 clear all");

    // R7 / R2: V5.2 link level
    v52_link = 1'b1; step(1);
    expect_out(8'h02, 1'b0, "R7 link rise");
    v52_link = 1'b0; step(1);
    expect_out(8'h22, 1'b0, "R7 R2 link fall, detect sticky");
    host_clear(8'hFF);

    // R9: event and clear on the same bit in one cycle
    v52_link = 1'b1; wr_en = 1'b1; wr_data = 8'h02;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
    expect_out(8'h02, 1'b0, "R9 event beats clear");
    host_clear(8'hFF);
    v52_link = 1'b0; step(1);
    expect_out(8'h20, 1'b0, "R7 second fall");
    host_clear(8'h20);

    // R5: distant multiframe alarm
    ts16(1'b1, 8'h04);
    expect_out(8'h00, 1'b0, "R5 one multiframe not enough");
    ts16(1'b0, 8'hFF);
    ts16(1'b0, 8'hFF);
    expect_out(8'h00, 1'b0, "R5 non-frame0 ignored");
    ts16(1'b1, 8'h04);
    expect_out(8'h01, 1'b0, "R5 alarm detect");

    // R6: alarm clearing with an interrupted run
    ts16(1'b1, 8'hFB);
    expect_out(8'h01, 1'b0, "R6 single zero not enough");
    ts16(1'b1, 8'h04);
    ts16(1'b1, 8'h00);
    expect_out(8'h01, 1'b0, "R6 run restarted");
    ts16(1'b1, 8'h00);
    expect_out(8'h11, 1'b0, "R6 alarm cleared");

    // R10: interrupt masking
    set_ien(8'h44);
    expect_out(8'h11, 1'b0, "R10 enables on unset bits");
    set_ien(8'h10);
    expect_out(8'h11, 1'b1, "R10 enabled bit raises irq");
    host_clear(8'h10);
    expect_out(8'h01, 1'b0, "R10 irq drops with bit");
    set_ien(8'hFF);
    expect_out(8'h01, 1'b1, "R10 all enabled");
    host_clear(8'hFF);
    expect_out(8'h00, 1'b0, "R10 R8 final clear");

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule